// File: doc/BRIEF.md
# Merged Divide-Remainder Unit

This block is a multi-cycle integer divider that yields a quotient and a remainder from one operation. A two-bit width code selects an operand size of 8, 16, 32 or 64 bits, and a sign flag selects unsigned or two's-complement signed division. Both operands are read from the low bits of 64-bit source words. The two 64-bit results are returned together, one for the quotient destination and one for the remainder destination.

The caller pulses `start` while `busy` is low. The block then latches the operands and raises `busy`. A one-cycle `done` pulse marks the cycle in which `quot_o` and `rem_o` become valid. The results stay valid until the next `done`. There is no back-pressure. The unit accepts one operation at a time, and a `start` seen while `busy` is high is dropped. The caller must read the results in the `done` cycle or at any later time before it issues the next operation. Division by zero and signed overflow never trap; each has a fixed result.

Top module: `divrem_unit`

## Requirements
- R1: With `sign_sel`=0, the unit divides the low N bits as unsigned numbers (`width_sel` 0,1,2,3 gives N = 8,16,32,64). Both results are zero-extended to 64 bits.
- R2: With `sign_sel`=1, the quotient is rounded toward zero and the remainder has the sign of the dividend. Both results are sign-extended from bit N-1 to 64 bits.
- R3: Source bits at positions N and above have no effect on either result.
- R4: When the low N bits of the divisor are zero, `quot_o` is all ones across 64 bits. `rem_o` equals the dividend's low N bits, extended by the sign mode as in R1/R2.
- R5: A signed division of the most negative N-bit value by -1 returns that most negative value (sign-extended) as the quotient and 0 as the remainder.
- R6: `done` is high for exactly one cycle, N+2 cycles after the cycle whose rising edge accepted `start`. `busy` is high from the cycle after acceptance until `done`, and `busy` and `done` are never high together.
- R7: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R8: After reset, `busy`, `done`, `quot_o` and `rem_o` are all zero.
- R9: `quot_o` and `rem_o` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; taken when busy is low |
| sign_sel | input | 1 | 1 = signed, 0 = unsigned |
| width_sel | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| dividend_i | input | 64 | Dividend source word |
| divisor_i | input | 64 | Divisor source word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quot_o | output | 64 | Quotient destination value |
| rem_o | output | 64 | Remainder destination value |

## Verification
The 8-bit mode is swept over every dividend against a divisor set that covers zero, one, small primes, powers of two and the signed extremes, in both sign modes. This separates errors in magnitude handling from errors in sign correction and extension. The upper source bits are filled with a fixed non-zero pattern, so any leak from outside the selected width shows up. The 16-, 32- and 64-bit modes are run against corner pairs: the most negative value over -1 and over 1, mixed-sign pairs with non-zero remainders, and zero divisors. Each width also has its completion latency measured. A second `start` is injected mid-operation, and the results are checked to hold after `done`.

// File: rtl/divrem_pkg.sv
package divrem_pkg;
  parameter int XLEN = 64;
  localparam int CNT_W = $clog2(XLEN + 1);

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2,
    WSEL_64 = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIN  = 2'd3
  } dstate_e;

  // operand size in bits for a width code: XLEN/8 .. XLEN
  function automatic int unsigned op_bits(wsel_e w);
    return XLEN >> (3 - int'(w));
  endfunction

  function automatic word_t low_mask(wsel_e w);
    return {XLEN{1'b1}} >> (XLEN - op_bits(w));
  endfunction

  function automatic logic top_bit(word_t v, wsel_e w);
    return v[op_bits(w) - 1];
  endfunction

  // keep the low N bits, fill the rest with the sign when signed
  function automatic word_t extend(word_t v, wsel_e w, logic sgn);
    word_t m;
    m = low_mask(w);
    return (v & m) | ((sgn && top_bit(v, w)) ? ~m : '0);
  endfunction
endpackage

// File: rtl/divrem_operand_prep.sv
module divrem_operand_prep
  import divrem_pkg::*;
(
  input  word_t dvd_i,
  input  word_t dvs_i,
  input  wsel_e wsel_i,
  input  logic  sgn_i,
  output word_t dvd_aligned_o,
  output word_t dvs_mag_o,
  output logic  q_neg_o,
  output logic  r_neg_o,
  output logic  dvs_zero_o,
  output word_t dvd_ext_o
);
  word_t mask;
  word_t dvd_x;
  word_t dvs_x;
  word_t dvd_mag;
  logic  dvd_neg;
  logic  dvs_neg;

  always_comb begin
    mask    = low_mask(wsel_i);
    dvd_x   = extend(dvd_i, wsel_i, sgn_i);
    dvs_x   = extend(dvs_i, wsel_i, sgn_i);
    dvd_neg = sgn_i && top_bit(dvd_i, wsel_i);
    dvs_neg = sgn_i && top_bit(dvs_i, wsel_i);
    dvd_mag = dvd_neg ? ((~dvd_x + 1'b1) & mask) : (dvd_x & mask);
    dvs_mag_o = dvs_neg ? ((~dvs_x + 1'b1) & mask) : (dvs_x & mask);
    // place dividend MSB at the top so every width shifts out the same way
    dvd_aligned_o = dvd_mag << (XLEN - op_bits(wsel_i));
    q_neg_o    = dvd_neg ^ dvs_neg;
    r_neg_o    = dvd_neg;
    dvs_zero_o = ((dvs_i & mask) == '0);
    dvd_ext_o  = dvd_x;
  end
endmodule

// File: rtl/divrem_core.sv
module divrem_core
  import divrem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  step_i,
  input  word_t dvd_aligned_i,
  input  word_t dvs_mag_i,
  output word_t quo_o,
  output word_t rem_o
);
  word_t part_rem;
  word_t shift_q;
  word_t quo_q;
  word_t dvs_q;

  logic [XLEN:0]   cand;
  logic [XLEN+1:0] diff;
  logic            borrow;

  always_comb begin
    cand   = {part_rem, shift_q[XLEN-1]};
    diff   = {1'b0, cand} - {2'b00, dvs_q};
    borrow = diff[XLEN+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_rem <= '0;
      shift_q  <= '0;
      quo_q    <= '0;
      dvs_q    <= '0;
    end else if (load_i) begin
      part_rem <= '0;
      shift_q  <= dvd_aligned_i;
      quo_q    <= '0;
      dvs_q    <= dvs_mag_i;
    end else if (step_i) begin
      shift_q <= {shift_q[XLEN-2:0], 1'b0};
      if (borrow) begin
        part_rem <= cand[XLEN-1:0];
        quo_q    <= {quo_q[XLEN-2:0], 1'b0};
      end else begin
        part_rem <= diff[XLEN-1:0];
        quo_q    <= {quo_q[XLEN-2:0], 1'b1};
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = part_rem;
endmodule

// File: rtl/divrem_result_fix.sv
module divrem_result_fix
  import divrem_pkg::*;
(
  input  word_t quo_i,
  input  word_t rem_i,
  input  wsel_e wsel_i,
  input  logic  sgn_i,
  input  logic  q_neg_i,
  input  logic  r_neg_i,
  input  logic  dvs_zero_i,
  input  word_t dvd_ext_i,
  output word_t quot_o,
  output word_t rem_o
);
  word_t q_s;
  word_t r_s;
  word_t q_by_w [4];
  word_t r_by_w [4];

  always_comb begin
    q_s = q_neg_i ? (~quo_i + 1'b1) : quo_i;
    r_s = r_neg_i ? (~rem_i + 1'b1) : rem_i;
  end

  // one extension lane per width code, selected below
  for (genvar g = 0; g < 4; g++) begin : g_ext
    localparam int NB = XLEN >> (3 - g);
    if (NB == XLEN) begin : g_full
      assign q_by_w[g] = q_s;
      assign r_by_w[g] = r_s;
    end else begin : g_part
      assign q_by_w[g] = {{(XLEN-NB){sgn_i & q_s[NB-1]}}, q_s[NB-1:0]};
      assign r_by_w[g] = {{(XLEN-NB){sgn_i & r_s[NB-1]}}, r_s[NB-1:0]};
    end
  end

  always_comb begin
    if (dvs_zero_i) begin
      quot_o = '1;
      rem_o  = dvd_ext_i;
    end else begin
      quot_o = q_by_w[wsel_i];
      rem_o  = r_by_w[wsel_i];
    end
  end
endmodule

// File: rtl/divrem_unit.sv
module divrem_unit
  import divrem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sign_sel,
  input  logic [1:0]  width_sel,
  input  logic [63:0] dividend_i,
  input  logic [63:0] divisor_i,
  output logic        busy,
  output logic        done,
  output logic [63:0] quot_o,
  output logic [63:0] rem_o
);
  dstate_e    state;
  word_t      dvd_q, dvs_q;
  wsel_e      wsel_q;
  logic       sgn_q;
  logic [CNT_W-1:0] cnt;

  logic  q_neg_q, r_neg_q, zero_q;
  word_t dvd_ext_q;

  word_t dvd_aligned, dvs_mag, dvd_ext_c;
  logic  q_neg_c, r_neg_c, zero_c;
  word_t core_quo, core_rem;
  word_t fin_quot, fin_rem;
  logic  accept;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  divrem_operand_prep u_prep (
    .dvd_i         (dvd_q),
    .dvs_i         (dvs_q),
    .wsel_i        (wsel_q),
    .sgn_i         (sgn_q),
    .dvd_aligned_o (dvd_aligned),
    .dvs_mag_o     (dvs_mag),
    .q_neg_o       (q_neg_c),
    .r_neg_o       (r_neg_c),
    .dvs_zero_o    (zero_c),
    .dvd_ext_o     (dvd_ext_c)
  );

  divrem_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (state == ST_PREP),
    .step_i        (state == ST_ITER),
    .dvd_aligned_i (dvd_aligned),
    .dvs_mag_i     (dvs_mag),
    .quo_o         (core_quo),
    .rem_o         (core_rem)
  );

  divrem_result_fix u_fix (
    .quo_i      (core_quo),
    .rem_i      (core_rem),
    .wsel_i     (wsel_q),
    .sgn_i      (sgn_q),
    .q_neg_i    (q_neg_q),
    .r_neg_i    (r_neg_q),
    .dvs_zero_i (zero_q),
    .dvd_ext_i  (dvd_ext_q),
    .quot_o     (fin_quot),
    .rem_o      (fin_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dvd_q     <= '0;
      dvs_q     <= '0;
      wsel_q    <= WSEL_8;
      sgn_q     <= 1'b0;
      cnt       <= '0;
      q_neg_q   <= 1'b0;
      r_neg_q   <= 1'b0;
      zero_q    <= 1'b0;
      dvd_ext_q <= '0;
      done      <= 1'b0;
      quot_o    <= '0;
      rem_o     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          dvd_q  <= dividend_i;
          dvs_q  <= divisor_i;
          wsel_q <= wsel_e'(width_sel);
          sgn_q  <= sign_sel;
          state  <= ST_PREP;
        end
        ST_PREP: begin
          q_neg_q   <= q_neg_c;
          r_neg_q   <= r_neg_c;
          zero_q    <= zero_c;
          dvd_ext_q <= dvd_ext_c;
          cnt       <= CNT_W'(op_bits(wsel_q));
          state     <= ST_ITER;
        end
        ST_ITER: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          quot_o <= fin_quot;
          rem_o  <= fin_rem;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divrem_unit_chk.sv
module divrem_unit_chk
  import divrem_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        sign_sel,
  input logic [1:0]  width_sel,
  input logic [63:0] dividend_i,
  input logic [63:0] divisor_i,
  input logic        busy,
  input logic        done,
  input logic [63:0] quot_o,
  input logic [63:0] rem_o
);
  logic [CNT_W+1:0] lat_cnt;
  logic [CNT_W+1:0] lat_exp;
  logic             zero_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      lat_exp  <= '0;
      zero_cap <= 1'b0;
    end else if (start && !busy) begin
      lat_cnt  <= '0;
      lat_exp  <= (CNT_W+2)'(op_bits(wsel_e'(width_sel)) + 2);
      zero_cap <= ((divisor_i & low_mask(wsel_e'(width_sel))) == '0);
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == lat_exp));
  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  // R4
  zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_cap) |-> (quot_o == '1));
  // R9
  hold_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quot_o) && $stable(rem_o)));
endmodule

bind divrem_unit divrem_unit_chk u_chk (.*);

// File: tb/sim_divrem_unit.sv
module sim_divrem_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sign_sel = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic [63:0] dividend_i = '0;
  logic [63:0] divisor_i = '0;
  logic        busy, done;
  logic [63:0] quot_o, rem_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  divrem_unit u0 (.*);

  localparam logic [63:0] JUNK = 64'hA5C3_96F0_1E2D_4B78;

  function automatic logic [63:0] msk(int w);
    return {64{1'b1}} >> (64 - (8 << w));
  endfunction

  function automatic logic [63:0] sx(logic [63:0] v, int w, bit sgn);
    logic [63:0] m;
    m = msk(w);
    return (v & m) | ((sgn && v[(8 << w) - 1]) ? ~m : 64'd0);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // arithmetic reference from the requirements
  task automatic model(bit sgn, int w, logic [63:0] a, logic [63:0] b,
                       output logic [63:0] eq, output logic [63:0] er);
    logic [63:0] m, au, bu;
    longint sa, sb;
    m  = msk(w);
    au = a & m;
    bu = b & m;
    if (bu == 0) begin
      eq = '1;
      er = sx(au, w, sgn);
    end else if (!sgn) begin
      eq = au / bu;
      er = au % bu;
    end else begin
      sa = longint'(sx(au, w, 1'b1));
      sb = longint'(sx(bu, w, 1'b1));
      if (sb == -1) begin
        eq = sx(64'(-sa) & m, w, 1'b1);
        er = '0;
      end else begin
        eq = sx(64'(sa / sb) & m, w, 1'b1);
        er = sx(64'(sa % sb) & m, w, 1'b1);
      end
    end
  endtask

  task automatic run_op(string req, bit sgn, int w, logic [63:0] a, logic [63:0] b,
                        bit inject);
    logic [63:0] eq, er;
    int lat;
    model(sgn, w, a, b, eq, er);
    @(negedge clk);
    sign_sel = sgn; width_sel = 2'(w); dividend_i = a; divisor_i = b; start = 1'b1;
    lat = 0;
    @(negedge clk); lat++;
    start = 1'b0;
    if (inject) begin
      @(negedge clk); lat++;
      @(negedge clk); lat++;
      dividend_i = ~a; divisor_i = b + 64'd3; sign_sel = ~sgn; width_sel = 2'd0;
      start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
    end
    while (!done && lat < 300) begin
      @(negedge clk); lat++;
    end
    // accepting edge plus N+2 further edges => N+3 negedges observed
    check(inject ? "R7" : "R6", "latency", 64'(lat), 64'((8 << w) + 3));
    check(req, "quotient", quot_o, eq);
    check(req, "remainder", rem_o, er);
  endtask

  initial begin
    #(190000 * 4);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] qh, rh;
    logic [63:0] dl [12];
    logic [63:0] mn, mx;
    dl = '{64'h00, 64'h01, 64'h02, 64'h03, 64'h05, 64'h07,
           64'h10, 64'h7F, 64'h80, 64'h81, 64'hFE, 64'hFF};
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "busy", 64'(busy), 64'd0);
    check("R8", "done", 64'(done), 64'd0);
    check("R8", "quot", quot_o, 64'd0);
    check("R8", "rem", rem_o, 64'd0);
    rst_n = 1'b1;

    // 8-bit sweep, upper bits loaded with junk (R1, R2, R3, R4, R5)
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 12; d++)
        for (int n = 0; n < 256; n++)
          run_op(s ? "R2/R3" : "R1/R3", bit'(s), 0,
                 (JUNK & ~64'hFF) | 64'(n), (~JUNK & ~64'hFF) | dl[d], 1'b0);

    // wider widths: corner pairs
    for (int w = 1; w < 4; w++) begin
      mn = 64'd1 << ((8 << w) - 1);
      mx = mn - 1;
      for (int s = 0; s < 2; s++) begin
        run_op(s ? "R2" : "R1", bit'(s), w, JUNK, 64'd13, 1'b0);
        run_op(s ? "R2" : "R1", bit'(s), w, sx(-64'd7, w, 1'b0), 64'd2, 1'b0);
        run_op(s ? "R2" : "R1", bit'(s), w, 64'd7, sx(-64'd2, w, 1'b0), 1'b0);
        run_op(s ? "R2" : "R1", bit'(s), w, mx, mn | 64'd5, 1'b0);
        run_op("R4", bit'(s), w, mn | 64'd9, JUNK & ~msk(w), 1'b0);
        run_op("R5", bit'(s), w, mn, msk(w), 1'b0);
        run_op(s ? "R2" : "R1", bit'(s), w, mn, 64'd1, 1'b0);
        run_op(s ? "R2" : "R1", bit'(s), w, 64'd0, msk(w), 1'b0);
      end
    end

    // explicit signed overflow at 64 bits (R5)
    run_op("R5", 1'b1, 3, 64'h8000_0000_0000_0000, '1, 1'b0);

    // start while busy (R7)
    run_op("R7", 1'b1, 2, 64'hFFFF_FFFF_8765_4321, 64'h0000_0000_0000_0123, 1'b1);
    run_op("R7", 1'b0, 1, 64'h0000_0000_0000_F00D, 64'h0000_0000_0000_0031, 1'b1);

    // R9 outputs hold after done
    qh = quot_o; rh = rem_o;
    repeat (6) @(negedge clk);
    check("R9", "quot hold", quot_o, qh);
    check("R9", "rem hold", rem_o, rh);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule